// File: doc/BRIEF.md
# Blanking Ancillary Packet Inserter

This block sits on a 10-bit digital component video stream. It replaces blanking samples on one chosen line with an ancillary data packet. The packet carries a small list of status bytes, which are loaded through a byte write port. The packet has a three-word preamble and three header words (data identifier, secondary identifier, word count). Each status byte is then sent as two user words with fixed marker bits. A checksum word closes the packet. The block supports a 10-bit word mode and an 8-bit word mode. In 8-bit mode the word occupies bits 9:2 of the port and bits 1:0 are zero.

There are two packet positions, each with its own enable and line select. The horizontal-blanking packet starts right after the end-of-active-video timing code. The vertical-blanking packet starts right after the start-of-active-video code on a line of the vertical interval. When embedded timing codes are switched off, a separate blanking flag marks the interval edges and the same packets are placed behind those edges. Every sample the block does not replace goes through unchanged. All samples, replaced or not, have a latency of two clock cycles.

Top module: `anc_inserter`

## Requirements
- R1: Packet words 0 to 2 are 000h, 3FFh, 3FFh in 10-bit mode. In 8-bit mode they are 000h, 3FCh, 3FCh on the port, which is 00h, FFh, FFh in bits 9:2.
- R2: Word 3 (identifier) in 10-bit mode is {~p, p, 4'b0100, did}, where p is the XOR of bits 7:0. In 8-bit mode, bits 9:2 are {4'b0100, did} and bits 1:0 are zero.
- R3: Word 4 (secondary identifier) in 10-bit mode is {~p, p, sdid}. In 8-bit mode, bits 9:2 are {sdid[7:2], 2'b00}.
- R4: Word 5 (count) carries the fixed value 2*NBYTES. In 10-bit mode it also carries the same parity pair as R2. In 8-bit mode it sits in bits 9:2.
- R5: Words 6 to 5+2*NBYTES carry the stored bytes, address 0 first. Each byte b gives two words: first {2'b01, b[7:4], 4'b0000}, then {2'b00, b[3:0], 4'b1000}. This holds in both modes.
- R6: The last word (6+2*NBYTES) is the checksum. S is the sum, with overflow dropped, of bits 8:0 of words 3 to 5+2*NBYTES; in 10-bit mode the word is {~S[8], S[8:0]}. In 8-bit mode S is the 7-bit sum of bits 8:2 and the word is {~S[6], S[6:0], 2'b00}.
- R7: With embedded codes on, the horizontal packet replaces the samples that follow an end-of-active code (XYZ bit 9 = 1, bit 6 = 1 after FFh, 00h, 00h in bits 9:2). This happens only when the horizontal enable is set and line_i equals the 5-bit horizontal line select.
- R8: With embedded codes on, the vertical packet replaces the samples that follow a start-of-active code (XYZ bit 6 = 0). This happens only when the vertical enable is set and line_i equals VANC_BASE plus the 4-bit vertical line select.
- R9: With embedded codes off, the horizontal packet is triggered by a rise of hblank_i and the vertical packet by a fall of hblank_i. The sample at the edge is kept, and the packet starts on the next sample.
- R10: A packet stops as soon as a timing reference begins. That is an input sample with bits 9:2 = FFh when codes are on, or a change of hblank_i when codes are off. That sample and all later ones pass unchanged, so timing codes are never overwritten.
- R11: Samples outside a packet pass unchanged with a latency of two cycles. Cleared enables or unselected lines produce no packet.
- R12: While rst is high, vid_o is 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_i | input | 10 | Incoming video sample |
| line_i | input | LINE_W | Current line number from the timing source |
| hblank_i | input | 1 | Blanking flag, used when embedded codes are off |
| fmt656_i | input | 1 | 1: embedded timing codes, 0: separate blanking flag |
| mode10_i | input | 1 | 1: 10-bit words, 0: 8-bit words in bits 9:2 |
| hanc_en_i | input | 1 | Horizontal-blanking packet enable |
| vanc_en_i | input | 1 | Vertical-blanking packet enable |
| hanc_line_i | input | 5 | Line for the horizontal packet |
| vanc_line_i | input | 4 | Line offset from VANC_BASE for the vertical packet |
| did_i | input | 4 | Low nibble of the identifier |
| sdid_i | input | 8 | Secondary identifier |
| byte_we_i | input | 1 | Status byte write strobe |
| byte_addr_i | input | AW | Status byte write address |
| byte_wdata_i | input | 8 | Status byte write data |
| vid_o | output | 10 | Outgoing video sample |

## Verification
Every sample, whether replaced or passed through, reaches vid_o exactly two rising edges after it is driven. The bench therefore builds the expected output word in the same cycle as each input word and pushes it into a queue. The monitor samples one nanosecond after each rising edge and pops an entry once two are pending, so each comparison lands on the sample the requirement names. The expected packet words are built from the bit formats in the requirements, including a separately computed checksum and parity. They are also placed at word offsets that count the one-sample start delay of R9 and the truncation at the timing code in R10.

// File: rtl/anc_pkg.sv
package anc_pkg;

  typedef enum logic [2:0] {
    WK_ADF0,
    WK_ADF1,
    WK_DID,
    WK_SDID,
    WK_DC,
    WK_UDW,
    WK_CS
  } wkind_e;

  // 10-bit header word with parity pair in bits 9:8
  function automatic logic [9:0] par_word(input logic [7:0] b);
    return {~(^b), ^b, b};
  endfunction

  // 8-bit field of one user word; lo selects the low-nibble word
  function automatic logic [7:0] udw_field(input logic [7:0] b, input logic lo);
    return lo ? {2'b00, b[3:0], 2'b10} : {2'b01, b[7:4], 2'b00};
  endfunction

endpackage

// File: rtl/anc_trc_detect.sv
module anc_trc_detect (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] code_i,
  input  logic       hblank_i,
  input  logic       fmt656_i,
  output logic       hstart_o,
  output logic       vstart_o,
  output logic       ref_o
);
  logic [7:0] h1, h2, h3;
  logic       hb_q;
  logic       xyz;

  always_ff @(posedge clk) begin
    if (rst) begin
      h1   <= '0;
      h2   <= '0;
      h3   <= '0;
      hb_q <= 1'b0;
    end else begin
      h1   <= code_i;
      h2   <= h1;
      h3   <= h2;
      hb_q <= hblank_i;
    end
  end

  assign xyz = (h3 == 8'hFF) && (h2 == 8'h00) && (h1 == 8'h00) && code_i[7];

  always_comb begin
    if (fmt656_i) begin
      hstart_o = xyz && code_i[4];
      vstart_o = xyz && !code_i[4];
      ref_o    = (code_i == 8'hFF);
    end else begin
      hstart_o = hblank_i && !hb_q;
      vstart_o = !hblank_i && hb_q;
      ref_o    = (hblank_i != hb_q);
    end
  end

  AST_TRIG_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hstart_o, vstart_o})); // R7
  AST_EDGE_IS_REF: assert property (@(posedge clk) disable iff (rst)
    (!fmt656_i && (hstart_o || vstart_o)) |-> ref_o); // R9

endmodule

// File: rtl/anc_byte_ram.sv
module anc_byte_ram #(
  parameter int NBYTES = 4,
  parameter int AW     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [NBYTES];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/anc_word_gen.sv
module anc_word_gen
  import anc_pkg::*;
#(
  parameter int NBYTES = 4,
  parameter int AW     = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic          mode10_i,
  input  logic [3:0]    did_i,
  input  logic [7:0]    sdid_i,
  input  logic [7:0]    rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic          rep_o,
  output logic [9:0]    word_o
);
  localparam int LAST = 6 + 2 * NBYTES;
  localparam int KW   = $clog2(LAST + 1);
  localparam logic [7:0] DC8 = 8'(2 * NBYTES);

  logic          active;
  logic [KW-1:0] k, koff;
  wkind_e        kind0, s1_kind;
  logic          s1_rep, s1_half;
  logic [8:0]    acc, low;
  logic [9:0]    w;

  // stage 0: word index
  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      k      <= '0;
    end else if (start_i) begin
      active <= 1'b1;
      k      <= '0;
    end else if (active && (abort_i || k == KW'(LAST))) begin
      active <= 1'b0;
    end else if (active) begin
      k <= k + 1'b1;
    end
  end

  assign koff = k - KW'(6);

  always_comb begin
    if (k == '0)                 kind0 = WK_ADF0;
    else if (k < KW'(3))         kind0 = WK_ADF1;
    else if (k == KW'(3))        kind0 = WK_DID;
    else if (k == KW'(4))        kind0 = WK_SDID;
    else if (k == KW'(5))        kind0 = WK_DC;
    else if (k == KW'(LAST))     kind0 = WK_CS;
    else                         kind0 = WK_UDW;
    raddr_o = (kind0 == WK_UDW) ? AW'(koff >> 1) : '0;
  end

  // stage 1: word build, byte read data aligned here
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rep  <= 1'b0;
      s1_kind <= WK_ADF0;
      s1_half <= 1'b0;
    end else begin
      s1_rep  <= active && !abort_i;
      s1_kind <= kind0;
      s1_half <= koff[0];
    end
  end

  always_comb begin
    case (s1_kind)
      WK_ADF0: w = 10'h000;
      WK_ADF1: w = mode10_i ? 10'h3FF : 10'h3FC;
      WK_DID:  w = mode10_i ? par_word({4'b0100, did_i}) : {4'b0100, did_i, 2'b00};
      WK_SDID: w = mode10_i ? par_word(sdid_i) : {sdid_i[7:2], 4'b0000};
      WK_DC:   w = mode10_i ? par_word(DC8) : {DC8, 2'b00};
      WK_UDW:  w = {udw_field(rdata_i, s1_half), 2'b00};
      default: w = mode10_i ? {~acc[8], acc} : {~acc[6], acc[6:0], 2'b00};
    endcase
    low = mode10_i ? w[8:0] : {2'b00, w[8:2]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (s1_rep) begin
      if (s1_kind == WK_DID) acc <= low;
      else if (s1_kind == WK_SDID || s1_kind == WK_DC || s1_kind == WK_UDW) acc <= acc + low;
    end
  end

  assign rep_o  = s1_rep;
  assign word_o = w;

  AST_K_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(active) && active && !$past(start_i)) |-> (k == $past(k) + 1'b1)); // R5
  AST_K_RANGE: assert property (@(posedge clk) disable iff (rst)
    active |-> (k <= KW'(LAST))); // R6
  AST_RADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    {1'b0, raddr_o} < (AW + 1)'(NBYTES)); // R5

endmodule

// File: rtl/anc_inserter.sv
module anc_inserter #(
  parameter int NBYTES    = 4,
  parameter int LINE_W    = 10,
  parameter int VANC_BASE = 10,
  parameter int AW        = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [9:0]        vid_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              hblank_i,
  input  logic              fmt656_i,
  input  logic              mode10_i,
  input  logic              hanc_en_i,
  input  logic              vanc_en_i,
  input  logic [4:0]        hanc_line_i,
  input  logic [3:0]        vanc_line_i,
  input  logic [3:0]        did_i,
  input  logic [7:0]        sdid_i,
  input  logic              byte_we_i,
  input  logic [AW-1:0]     byte_addr_i,
  input  logic [7:0]        byte_wdata_i,
  output logic [9:0]        vid_o
);
  logic          hstart, vstart, ref_hit, start;
  logic [AW-1:0] raddr;
  logic [7:0]    rdata;
  logic          rep;
  logic [9:0]    word;
  logic [9:0]    s1_vid;

  anc_trc_detect u_det (
    .clk      (clk),
    .rst      (rst),
    .code_i   (vid_i[9:2]),
    .hblank_i (hblank_i),
    .fmt656_i (fmt656_i),
    .hstart_o (hstart),
    .vstart_o (vstart),
    .ref_o    (ref_hit)
  );

  assign start = (hstart && hanc_en_i && (line_i == LINE_W'(hanc_line_i))) ||
                 (vstart && vanc_en_i &&
                  (line_i == LINE_W'(VANC_BASE) + LINE_W'(vanc_line_i)));

  anc_byte_ram #(.NBYTES(NBYTES), .AW(AW)) u_ram (
    .clk     (clk),
    .we_i    (byte_we_i),
    .waddr_i (byte_addr_i),
    .wdata_i (byte_wdata_i),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  anc_word_gen #(.NBYTES(NBYTES), .AW(AW)) u_gen (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .abort_i  (ref_hit),
    .mode10_i (mode10_i),
    .did_i    (did_i),
    .sdid_i   (sdid_i),
    .rdata_i  (rdata),
    .raddr_o  (raddr),
    .rep_o    (rep),
    .word_o   (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vid <= '0;
      vid_o  <= '0;
    end else begin
      s1_vid <= vid_i;
      vid_o  <= rep ? word : s1_vid;
    end
  end

  AST_REF_KEPT: assert property (@(posedge clk) disable iff (rst)
    (fmt656_i && vid_i[9:2] == 8'hFF) |-> ##2 (vid_o == $past(vid_i, 2))); // R10
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (!hanc_en_i && !vanc_en_i && $past(!hanc_en_i && !vanc_en_i) && !$past(rep) && !rep)
      |=> (vid_o == $past(s1_vid))); // R11

endmodule

// File: tb/tb_anc_inserter.sv
`timescale 1ns/1ps
module tb_anc_inserter;
  localparam int NB   = 4;
  localparam int LAST = 6 + 2 * NB;
  localparam int AW   = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst;
  logic [9:0] vid_i;
  logic [9:0] line_i;
  logic       hblank_i, fmt656_i, mode10_i, hanc_en_i, vanc_en_i;
  logic [4:0] hanc_line_i;
  logic [3:0] vanc_line_i, did_i;
  logic [7:0] sdid_i, byte_wdata_i;
  logic       byte_we_i;
  logic [AW-1:0] byte_addr_i;
  logic [9:0] vid_o;

  anc_inserter dut (
    .clk(clk), .rst(rst), .vid_i(vid_i), .line_i(line_i), .hblank_i(hblank_i),
    .fmt656_i(fmt656_i), .mode10_i(mode10_i), .hanc_en_i(hanc_en_i),
    .vanc_en_i(vanc_en_i), .hanc_line_i(hanc_line_i), .vanc_line_i(vanc_line_i),
    .did_i(did_i), .sdid_i(sdid_i), .byte_we_i(byte_we_i),
    .byte_addr_i(byte_addr_i), .byte_wdata_i(byte_wdata_i), .vid_o(vid_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [9:0] qw[$];
  string      qt[$];
  logic [7:0] bytes_m[NB];
  logic [9:0] pkt[LAST+1];

  task automatic chk(string tag, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %03h expected %03h at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor: output is due two rising edges after the input was driven
  always @(posedge clk) begin
    #1;
    if (qw.size() >= 2) chk(qt.pop_front(), vid_o, qw.pop_front());
  end

  task automatic step(logic [9:0] v, logic hb, logic [9:0] e, string tag);
    @(negedge clk);
    vid_i    = v;
    hblank_i = hb;
    qw.push_back(e);
    qt.push_back(tag);
  endtask

  function automatic logic [9:0] pw(logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += b[i];
    return {(n % 2) == 0, (n % 2) == 1, b};
  endfunction

  function automatic string tag_of(int k, string place);
    if (k == 0) return place;
    if (k < 3) return "R1";
    if (k == 3) return "R2";
    if (k == 4) return "R3";
    if (k == 5) return "R4";
    if (k == LAST) return "R6";
    return "R5";
  endfunction

  task automatic build_pkt(bit m10);
    logic [31:0] s = 0;
    pkt[0] = 10'h000;
    pkt[1] = m10 ? 10'h3FF : 10'h3FC;
    pkt[2] = pkt[1];
    pkt[3] = m10 ? pw({4'b0100, did_i}) : {4'b0100, did_i, 2'b00};
    pkt[4] = m10 ? pw(sdid_i) : {sdid_i[7:2], 4'b0000};
    pkt[5] = m10 ? pw(8'(2 * NB)) : {8'(2 * NB), 2'b00};
    for (int i = 0; i < NB; i++) begin
      pkt[6 + 2*i] = {2'b01, bytes_m[i][7:4], 4'b0000};
      pkt[7 + 2*i] = {2'b00, bytes_m[i][3:0], 4'b1000};
    end
    for (int k = 3; k < LAST; k++) s += m10 ? 32'(pkt[k][8:0]) : 32'(pkt[k][8:2]);
    pkt[LAST] = m10 ? {~s[8], s[8:0]} : {~s[6], s[6:0], 2'b00};
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(10'h040, 1'b0, 10'h040, "R11");
  endtask

  task automatic wr_bytes(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, logic [7:0] b3);
    bytes_m[0] = b0; bytes_m[1] = b1; bytes_m[2] = b2; bytes_m[3] = b3;
    for (int i = 0; i < NB; i++) begin
      step(10'h040, 1'b0, 10'h040, "R11");
      byte_we_i = 1'b1; byte_addr_i = AW'(i); byte_wdata_i = bytes_m[i];
    end
    step(10'h040, 1'b0, 10'h040, "R11");
    byte_we_i = 1'b0;
  endtask

  task automatic line656(int ln, int hbl, int act, bit hsel, bit vsel, bit m10);
    logic [9:0] m = m10 ? 10'h3FF : 10'h3FC;
    logic [9:0] v;
    string      ptag = hsel ? "R10" : "R11";
    line_i = 10'(ln);
    build_pkt(m10);
    step(10'h3FF & m, 0, 10'h3FF & m, "R11");
    step(10'h000, 0, 10'h000, "R11");
    step(10'h000, 0, 10'h000, "R11");
    step(10'h274, 0, 10'h274, "R11");
    for (int j = 0; j < hbl; j++) begin
      v = ((j % 2) != 0) ? 10'h040 : 10'h200;
      if (hsel && j <= LAST) step(v, 0, pkt[j], tag_of(j, "R7"));
      else step(v, 0, v, ptag);
    end
    step(10'h3FF & m, 0, 10'h3FF & m, ptag);
    step(10'h000, 0, 10'h000, ptag);
    step(10'h000, 0, 10'h000, ptag);
    step(10'h200, 0, 10'h200, ptag);
    for (int j = 0; j < act; j++) begin
      v = (10'h100 + 10'(j)) & m;
      if (vsel && j <= LAST) step(v, 0, pkt[j], tag_of(j, "R8"));
      else step(v, 0, v, "R11");
    end
  endtask

  task automatic line601(int ln, int hbl, int act, bit hsel, bit vsel);
    logic [9:0] v;
    line_i = 10'(ln);
    build_pkt(1'b1);
    for (int j = 0; j < hbl; j++) begin
      v = ((j % 2) != 0) ? 10'h040 : 10'h200;
      if (hsel && j >= 1 && j - 1 <= LAST) step(v, 1, pkt[j-1], tag_of(j - 1, "R9"));
      else step(v, 1, v, hsel ? "R9" : "R11");
    end
    for (int j = 0; j < act; j++) begin
      v = 10'h100 + 10'(j);
      if (vsel && j >= 1 && j - 1 <= LAST) step(v, 0, pkt[j-1], tag_of(j - 1, "R9"));
      else step(v, 0, v, "R10");
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; vid_i = '0; line_i = '0; hblank_i = 0; fmt656_i = 1; mode10_i = 1;
    hanc_en_i = 0; vanc_en_i = 0; hanc_line_i = 5'd5; vanc_line_i = 4'd3;
    did_i = 4'h7; sdid_i = 8'h5A; byte_we_i = 0; byte_addr_i = '0; byte_wdata_i = '0;
    repeat (3) @(negedge clk);
    chk("R12", vid_o, 10'h000);
    rst = 1'b0;
    wr_bytes(8'hA5, 8'h3C, 8'hFF, 8'h00);
    hanc_en_i = 1;
    idle(4);
    // R7: horizontal packet on line 5 only
    line656(4, 24, 40, 0, 0, 1);
    line656(5, 24, 40, 1, 0, 1);
    line656(6, 24, 40, 0, 0, 1);
    // R8: vertical packet on line VANC_BASE + 3
    hanc_en_i = 0; vanc_en_i = 1;
    line656(12, 24, 40, 0, 0, 1);
    line656(13, 24, 40, 0, 1, 1);
    // R10: blanking too short, packet cut at the timing code
    vanc_en_i = 0; hanc_en_i = 1;
    line656(5, 10, 20, 1, 0, 1);
    // 8-bit word mode with new bytes and identifiers
    did_i = 4'hC; sdid_i = 8'hE7;
    wr_bytes(8'h12, 8'h80, 8'h7F, 8'hE1);
    mode10_i = 0;
    line656(5, 24, 40, 1, 0, 0);
    line656(9, 24, 40, 0, 0, 0);
    mode10_i = 1;
    line656(5, 24, 40, 1, 0, 1);
    // R9: separate blanking flag
    fmt656_i = 0; vanc_en_i = 1;
    line601(5, 28, 40, 1, 0);
    line601(13, 28, 40, 0, 1);
    line601(7, 28, 40, 0, 0);
    // R11: enables cleared
    hanc_en_i = 0; vanc_en_i = 0;
    line601(5, 28, 40, 0, 0);
    fmt656_i = 1;
    line656(5, 24, 40, 0, 0, 1);
    line656(13, 24, 40, 0, 0, 1);
    idle(4);
    @(posedge clk); #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule